// File: doc/BRIEF.md
# Strobed Parallel Port Controller

This block is a register-mapped 8-bit parallel I/O unit. It has one bidirectional port, with a data register and a per-pin direction register. It also has a capture register that takes a snapshot of that port's pins when an external input strobe reaches its active edge. A sticky capture flag records each snapshot and can raise an interrupt request. Software clears the flag with a two-read sequence: it first reads the control register while the flag is set, then reads the capture register.

A second register drives a fixed-output port. Every write to that register sends a timed pulse on an output strobe pin, which tells an external receiver that new data is present. The control register selects four things: the active edge of the input strobe, the active level of the output strobe, open-drain drive for the bidirectional pins, and whether the flag raises an interrupt. Pins are modelled as separate input, output and output-enable vectors.

Register map, by `addr`:
- 0: bidirectional data.
- 1: direction.
- 2: capture register, read only.
- 3: control.
- 4: fixed output.

Other addresses read as zero. Reads are combinational from `addr`. The clock edge on which `rd_en` is high is the edge at which the read counts for the clearing sequence.

Top module: `strobe_pio`

## Requirements
- R1: After reset the outputs and registers hold these values:
  - `pin_oe`, `irq`, the direction register and the fixed output are 0.
  - The control register reads 0x01: output polarity is 1 and every other bit is 0.
  - `ostb` is low.
- R2: A direction bit of 1 drives that pin: `pin_oe` is 1 and `pin_out` is the data bit. A direction bit of 0 releases the pin. A read of address 0 returns `pin_in` for input bits and the data register for output bits.
- R3: The input strobe passes through a two-flop synchroniser. On its active edge, `pin_in` is copied into the capture register (address 2), which keeps that value until the next active edge. Control bit 1 selects the edge: 0 means falling, 1 means rising.
- R4: Control bit 7 is the capture flag. It sets on every capture. `irq` is 1 exactly while the flag is 1 and the interrupt enable (control bit 6) is 1.
- R5: The flag clears on a read of address 2 that comes after a read of address 3 made while the flag was set. A read of address 2 without that earlier read leaves the flag set.
- R6: Writes to control bit 7 have no effect. If a capture occurs at any point in the clearing sequence, including in the same cycle as the read of address 2, the flag stays set.
- R7: Control bit 5 selects open-drain mode. In that mode an output pin drives 0 when its data bit is 0 and is released when its data bit is 1. A pin is never driven high in this mode.
- R8: A write to address 4 updates `fixed_out` and makes `ostb` active for exactly 2 clock cycles, starting the cycle after the write edge. Control bit 0 sets the active level: 1 means high, 0 means low.
- R9: Control bits 4 to 2 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_in | input | 8 | Bidirectional port pin levels |
| pin_out | output | 8 | Bidirectional port drive values |
| pin_oe | output | 8 | Bidirectional port drive enables |
| stb_in | input | 1 | External input strobe |
| fixed_out | output | 8 | Fixed-output port |
| ostb | output | 1 | Output strobe |
| irq | output | 1 | Interrupt request |

## Verification
The capture of a strobe edge can land in the same cycle as the capture-register read that would clear the flag. The bench provokes this by changing `stb_in` exactly three clock edges before issuing that read, which covers the synchroniser and the edge-detect stage. The read must return the old captured value. The flag must stay set afterwards, and a later read of the capture register must show the new value. A write to the control register that tries to clear the flag is checked in the same way: the flag must be unchanged while it is set.

// File: rtl/strobe_pio.sv
module strobe_pio #(
  parameter int W = 8,
  parameter int AW = 3,
  parameter int PULSE_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  input  logic          stb_in,
  output logic [W-1:0]  fixed_out,
  output logic          ostb,
  output logic          irq
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [AW-1:0] A_DATA  = AW'(0);
  localparam logic [AW-1:0] A_DIR   = AW'(1);
  localparam logic [AW-1:0] A_CAP   = AW'(2);
  localparam logic [AW-1:0] A_CTRL  = AW'(3);
  localparam logic [AW-1:0] A_FIXED = AW'(4);

  logic [W-1:0]  dir_q, dout_q, cap_q, fix_q;
  logic          flag_q, ien_q, wor_q, edge_q, pol_q, armed_q;
  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q;

  wire sel_data  = (addr == A_DATA);
  wire sel_dir   = (addr == A_DIR);
  wire sel_cap   = (addr == A_CAP);
  wire sel_ctrl  = (addr == A_CTRL);
  wire sel_fixed = (addr == A_FIXED);

  wire cap_evt  = edge_q ? (s2_q & ~s3_q) : (~s2_q & s3_q);
  wire rd_cap   = rd_en & sel_cap;
  wire rd_ctrl  = rd_en & sel_ctrl;
  wire clr_flag = rd_cap & armed_q & ~cap_evt;
  wire ostb_act = (cnt_q != '0);

  wire [7:0] ctrl_rd = {flag_q, ien_q, wor_q, 3'b000, edge_q, pol_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= stb_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      dout_q <= '0;
      fix_q  <= '0;
      ien_q  <= 1'b0;
      wor_q  <= 1'b0;
      edge_q <= 1'b0;
      pol_q  <= 1'b1;
    end else if (wr_en) begin
      if (sel_data)  dout_q <= wdata;
      if (sel_dir)   dir_q  <= wdata;
      if (sel_fixed) fix_q  <= wdata;
      if (sel_ctrl) begin
        ien_q  <= wdata[6];
        wor_q  <= wdata[5];
        edge_q <= wdata[1];
        pol_q  <= wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= pin_in;
      if (cap_evt)       flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      if (cap_evt)      armed_q <= 1'b0;
      else if (rd_ctrl) armed_q <= flag_q;
      else if (rd_cap)  armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (wr_en && sel_fixed) cnt_q <= CW'(PULSE_CYCLES);
    else if (ostb_act)        cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    rdata = '0;
    unique case (1'b1)
      sel_data:  rdata = (dir_q & dout_q) | (~dir_q & pin_in);
      sel_dir:   rdata = dir_q;
      sel_cap:   rdata = cap_q;
      sel_ctrl:  rdata = W'(ctrl_rd);
      sel_fixed: rdata = fix_q;
      default:   rdata = '0;
    endcase
  end

  assign pin_out   = wor_q ? '0 : dout_q;
  assign pin_oe    = wor_q ? (dir_q & ~dout_q) : dir_q;
  assign fixed_out = fix_q;
  assign ostb      = pol_q ? ostb_act : ~ostb_act;
  assign irq       = flag_q & ien_q;

  p_in_nodrive_r2: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~dir_q) == '0);

  p_cap_value_r3: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_q == $past(pin_in));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flag_q);

  p_no_unarmed_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(rd_cap && armed_q)) |=> flag_q);

  p_flag_wr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_ctrl && !cap_evt && !rd_cap) |=> flag_q == $past(flag_q));

  p_od_never_high_r7: assert property (@(posedge clk) disable iff (rst)
    wor_q |-> (pin_oe & pin_out) == '0);

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_fixed) |=> ostb_act && fixed_out == $past(wdata));
endmodule

// File: tb/tb_strobe_pio.sv
module tb_strobe_pio;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] addr = '0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe, fixed_out;
  logic       stb_in = 0, ostb, irq;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t q[$];

  strobe_pio dut (.clk, .rst, .addr, .wr_en, .rd_en, .wdata, .rdata,
                  .pin_in, .pin_out, .pin_oe, .stb_in, .fixed_out, .ostb, .irq);

  always #2 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rd_en && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(rdata, it.exp, it.req);
    end
  end

  // all tasks start right after a falling edge and end on one
  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [7:0] e, input string req);
    item_t it;
    addr = a; rd_en = 1;
    it.exp = e; it.req = req;
    q.push_back(it);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    // R1
    chk(pin_oe, 8'h00, "R1 oe");
    chk(irq, 0, "R1 irq");
    chk(ostb, 0, "R1 ostb");
    chk(fixed_out, 8'h00, "R1 fixed");
    do_read(3'd3, 8'h01, "R1 ctrl");
    do_read(3'd1, 8'h00, "R1 dir");
    // R2
    pin_in = 8'h3C;
    do_write(3'd0, 8'hA5);
    do_write(3'd1, 8'hF0);
    chk(pin_oe, 8'hF0, "R2 oe");
    chk(pin_out & pin_oe, 8'hA0, "R2 out");
    do_read(3'd0, 8'hAC, "R2 mixed read");
    // R7
    do_write(3'd3, 8'h21);
    chk(pin_oe, 8'h50, "R7 od oe");
    chk(pin_out & pin_oe, 8'h00, "R7 od never high");
    do_write(3'd3, 8'h01);
    // R3 R4: falling edge default, irq off
    pin_in = 8'h5A;
    stb_in = 1; idle(5);
    do_read(3'd3, 8'h01, "R3 rising ignored");
    stb_in = 0; idle(5);
    do_read(3'd2, 8'h5A, "R3 falling capture");
    chk(irq, 0, "R4 irq masked");
    do_write(3'd3, 8'h41);
    chk(irq, 1, "R4 irq asserted");
    // R5: capture read without arming keeps flag
    do_read(3'd2, 8'h5A, "R5 unarmed read");
    do_read(3'd3, 8'hC1, "R5 flag kept");
    do_read(3'd2, 8'h5A, "R5 armed read");
    do_read(3'd3, 8'h41, "R5 flag cleared");
    chk(irq, 0, "R4 irq dropped");
    // R6: write to flag bit, capture mid-sequence
    do_write(3'd3, 8'hC1);
    do_read(3'd3, 8'h41, "R6 flag write ignored");
    pin_in = 8'h77;
    stb_in = 1; idle(4); stb_in = 0; idle(5);
    do_write(3'd3, 8'h41);
    do_read(3'd3, 8'hC1, "R6 flag write keeps set");
    pin_in = 8'h11;
    stb_in = 1; idle(3); stb_in = 0; idle(5);
    do_read(3'd2, 8'h11, "R6 capture mid sequence");
    do_read(3'd3, 8'hC1, "R6 flag still set");
    // same-cycle capture and clearing read
    pin_in = 8'h99;
    stb_in = 1; idle(5);
    stb_in = 0; idle(2);
    do_read(3'd2, 8'h11, "R6 same cycle old value");
    do_read(3'd3, 8'hC1, "R6 same cycle flag set");
    do_read(3'd2, 8'h99, "R3 new value");
    do_read(3'd3, 8'h41, "R5 cleared after");
    // R3 rising select, R9 reserved bits
    do_write(3'd3, 8'h1F);
    do_read(3'd3, 8'h03, "R9 reserved zero");
    pin_in = 8'h42;
    stb_in = 1; idle(5);
    do_read(3'd2, 8'h42, "R3 rising capture");
    pin_in = 8'h00;
    stb_in = 0; idle(5);
    do_read(3'd2, 8'h42, "R3 hold on falling");
    // R8 active high pulse
    do_write(3'd4, 8'h6E);
    chk(ostb, 1, "R8 pulse c1");
    chk(fixed_out, 8'h6E, "R8 data");
    idle(1); chk(ostb, 1, "R8 pulse c2");
    idle(1); chk(ostb, 0, "R8 pulse end");
    // R8 active low
    do_write(3'd3, 8'h00);
    chk(ostb, 1, "R8 low idle");
    do_write(3'd4, 8'h01);
    chk(ostb, 0, "R8 low c1");
    idle(1); chk(ostb, 0, "R8 low c2");
    idle(1); chk(ostb, 1, "R8 low end");
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule